// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This unit sits between a processor pipeline and a word-wide data memory. Each request brings an opcode, a base register value, a 16-bit signed displacement and, for stores, a source register value. The unit adds the base to the sign-extended displacement to form a byte address, turns it into a word index and a lane number, and drives a one-cycle memory access with per-byte write enables. It handles whole-word loads and stores, byte stores, and byte loads with either sign or zero extension.

Byte lanes follow big-endian order. The byte at the word-aligned address is the most significant byte of the word. A store lays its data out on the lanes, and for a byte store the write enables keep the other three bytes of the word intact. For a load, the unit picks the addressed byte from the word the memory returns and widens it. A word access whose address is not a multiple of four starts no memory access and raises a one-cycle error pulse instead.

The memory must present the addressed word on `mem_rdata` combinationally during the cycle in which `mem_req` is high. Writes take effect at the clock edge that ends that cycle.

Top module: `lsu_byte_lane`

## Requirements
- R1: The byte address is `req_base` plus `req_offset` sign-extended to 32 bits, with wrap-around. `mem_addr` carries bits 31:2 of that sum in the cycle after an accepted request, with `mem_req` high in that cycle.
- R2: Opcode encoding on `req_op`: 0 = word load, 1 = word store, 2 = signed byte load, 3 = unsigned byte load, 4 = byte store. Values 5 to 7 are ignored, and so is any request with `req_valid` low: no `mem_req`, no `ld_valid` and no `align_err` results.
- R3: A word store drives `mem_be` = 4'b1111 and `mem_wdata` = `req_src`.
- R4: A byte store drives a one-hot `mem_be` in which `mem_be[k]` enables bits 8k+7:8k. Address bits 1:0 = 00 select `mem_be[3]` and 11 select `mem_be[0]`. `mem_wdata` is `req_src[7:0]` copied onto all four lanes.
- R5: A byte store changes only the addressed byte. A later word load of the same word returns the other three bytes as they were.
- R6: A signed byte load returns the addressed byte (address bits 1:0 = 00 is bits 31:24 of the memory word) in `ld_data[7:0]`, with bits 31:8 copies of its bit 7.
- R7: An unsigned byte load returns the addressed byte in `ld_data[7:0]` with bits 31:8 zero.
- R8: A word load returns the whole memory word unchanged.
- R9: A load drives `mem_be` = 0 and `mem_wdata` = 0 during its `mem_req` cycle. `ld_valid` is high with the result in the following cycle, two cycles after the request. Requests may arrive every cycle.
- R10: A word load or word store whose address bits 1:0 are nonzero produces `align_err` high for exactly the one cycle after the request, with no `mem_req`, no write and no `ld_valid`. Byte accesses never raise `align_err`.
- R11: After reset, `mem_req`, `mem_be`, `mem_wdata`, `mem_addr`, `ld_valid`, `ld_data` and `align_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Access opcode (see R2) |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed byte displacement |
| req_src | input | 32 | Store source register value |
| mem_req | output | 1 | Memory access this cycle |
| mem_addr | output | 30 | Word index into memory |
| mem_be | output | 4 | Per-byte write enables, bit k = bits 8k+7:8k |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_rdata | input | 32 | Word read from `mem_addr` during `mem_req` |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| align_err | output | 1 | One-cycle pulse for a misaligned word access |

## Verification
The hardest case to reach from the ports is a byte store followed at once by a word load of the same word. That is the only sequence that shows the three untouched lanes really kept their old contents, so the write enables have to line up with the memory model's write in the cycle just before the read. The stimulus writes every lane with a distinct byte, issuing each store right after the previous one, and reads the merged word back in the next cycle. It also sends misaligned word stores to a word whose contents are known and reads that word back, to show that the error path wrote nothing. Displacements are chosen negative and at both ends of the 16-bit range so that the sign extension decides which word is touched.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  typedef enum logic [2:0] {
    OP_LW  = 3'd0,
    OP_SW  = 3'd1,
    OP_LB  = 3'd2,
    OP_LBU = 3'd3,
    OP_SB  = 3'd4
  } mem_op_e;

  function automatic logic f_op_known(input logic [2:0] op);
    return (op <= 3'd4);
  endfunction

  function automatic logic f_op_word(input logic [2:0] op);
    return (op == OP_LW) || (op == OP_SW);
  endfunction

  function automatic logic f_op_load(input logic [2:0] op);
    return (op == OP_LW) || (op == OP_LB) || (op == OP_LBU);
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANES  = 4,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0]       base,
  input  logic [OFF_W-1:0]        offset,
  input  logic                    word_access,
  output logic [ADDR_W-LSB_W-1:0] word_idx,
  output logic [LSB_W-1:0]        lane_sel,
  output logic                    misaligned
);

  function automatic logic [ADDR_W-1:0] f_sext(input logic [OFF_W-1:0] v);
    return {{(ADDR_W-OFF_W){v[OFF_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] f_eff(input logic [ADDR_W-1:0] b,
                                              input logic [OFF_W-1:0]  o);
    return b + f_sext(o);
  endfunction

  logic [ADDR_W-1:0] eff_addr;

  assign eff_addr   = f_eff(base, offset);
  assign word_idx   = eff_addr[ADDR_W-1:LSB_W];
  assign lane_sel   = eff_addr[LSB_W-1:0];
  assign misaligned = word_access & (|lane_sel);

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic              word_st,
  input  logic              byte_st,
  input  logic [LSB_W-1:0]  lane_sel,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);

  // big-endian: lane number 0 (lowest address) is the top byte
  function automatic logic f_lane_hit(input logic [LSB_W-1:0] sel, input int k);
    return sel == LSB_W'(LANES - 1 - k);
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign be[k] = word_st | (byte_st & f_lane_hit(lane_sel, k));
    assign wdata[k*8 +: 8] = word_st ? src[k*8 +: 8] :
                             (byte_st ? src[7:0] : 8'h00);
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [LSB_W-1:0]  lane_sel,
  input  logic              word_ld,
  input  logic              sign_ext,
  output logic [DATA_W-1:0] data
);

  logic [7:0] lane_byte [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_split
    assign lane_byte[k] = rdata[k*8 +: 8];
  end

  function automatic logic [DATA_W-1:0] f_extend(input logic [7:0] b, input logic s);
    return {{(DATA_W-8){s & b[7]}}, b};
  endfunction

  logic [7:0] picked;

  always_comb begin
    picked = 8'h00;
    for (int k = 0; k < LANES; k++) begin
      if (lane_sel == LSB_W'(LANES - 1 - k)) picked = lane_byte[k];
    end
  end

  assign data = word_ld ? rdata : f_extend(picked, sign_ext);

endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES),
  localparam int IDX_W = DATA_W - LSB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [DATA_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_src,
  output logic              mem_req,
  output logic [IDX_W-1:0]  mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              align_err
);

  logic             op_known, op_word, op_load;
  logic [IDX_W-1:0] word_idx;
  logic [LSB_W-1:0] lane_sel;
  logic             misaligned;
  logic [LANES-1:0] st_be;
  logic [DATA_W-1:0] st_wdata;

  // named events used by the checker
  logic ev_issue, ev_misalign, ev_sext, ev_zext;

  assign op_known = req_valid & f_op_known(req_op);
  assign op_word  = f_op_word(req_op);
  assign op_load  = f_op_load(req_op);

  lsu_addr_gen #(.ADDR_W(DATA_W), .OFF_W(OFF_W), .LANES(LANES)) u_addr (
    .base       (req_base),
    .offset     (req_offset),
    .word_access(op_word),
    .word_idx   (word_idx),
    .lane_sel   (lane_sel),
    .misaligned (misaligned)
  );

  lsu_store_lane #(.DATA_W(DATA_W)) u_store (
    .word_st (req_op == OP_SW),
    .byte_st (req_op == OP_SB),
    .lane_sel(lane_sel),
    .src     (req_src),
    .be      (st_be),
    .wdata   (st_wdata)
  );

  assign ev_issue    = op_known & ~misaligned;
  assign ev_misalign = op_known & misaligned;

  // load pipeline state: stage 1 = memory cycle, stage 2 = result cycle
  logic             s1_load, s1_sign, s1_word;
  logic [LSB_W-1:0] s1_lane;
  logic             s2_sign, s2_word;
  logic [DATA_W-1:0] ext_data;

  lsu_load_extract #(.DATA_W(DATA_W)) u_load (
    .rdata   (mem_rdata),
    .lane_sel(s1_lane),
    .word_ld (s1_word),
    .sign_ext(s1_sign),
    .data    (ext_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      align_err <= 1'b0;
      s1_load   <= 1'b0;
      s1_sign   <= 1'b0;
      s1_word   <= 1'b0;
      s1_lane   <= '0;
      s2_sign   <= 1'b0;
      s2_word   <= 1'b0;
      ld_valid  <= 1'b0;
      ld_data   <= '0;
    end else begin
      mem_req   <= ev_issue;
      align_err <= ev_misalign;
      if (ev_issue) mem_addr <= word_idx;
      mem_be    <= ev_issue ? st_be : '0;
      mem_wdata <= ev_issue ? st_wdata : '0;
      s1_load   <= ev_issue & op_load;
      s1_sign   <= req_op == OP_LB;
      s1_word   <= req_op == OP_LW;
      s1_lane   <= lane_sel;
      ld_valid  <= s1_load;
      if (s1_load) begin
        ld_data <= ext_data;
        s2_sign <= s1_sign;
        s2_word <= s1_word;
      end
    end
  end

  assign ev_sext = ld_valid & s2_sign & ~s2_word;
  assign ev_zext = ld_valid & ~s2_sign & ~s2_word;

endmodule

// File: rtl/lsu_byte_lane_chk.sv
module lsu_byte_lane_chk
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES),
  localparam int IDX_W = DATA_W - LSB_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [DATA_W-1:0] req_base,
  input logic [OFF_W-1:0]  req_offset,
  input logic              mem_req,
  input logic [IDX_W-1:0]  mem_addr,
  input logic [LANES-1:0]  mem_be,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              ld_valid,
  input logic [DATA_W-1:0] ld_data,
  input logic              align_err,
  input logic              ev_issue,
  input logic              ev_sext,
  input logic              ev_zext
);

  logic [DATA_W-1:0] chk_ea;
  logic              chk_word_op, chk_byte_op;

  assign chk_ea      = req_base + DATA_W'($signed(req_offset));
  assign chk_word_op = req_valid && (req_op == OP_LW || req_op == OP_SW);
  assign chk_byte_op = req_valid && (req_op == OP_LB || req_op == OP_LBU || req_op == OP_SB);

  AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |=> mem_req && mem_addr == $past(chk_ea[DATA_W-1:LSB_W])); // R1

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == '0 || mem_be == '1 || $countones(mem_be) == 1)); // R3

  AST_BYTE_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $countones(mem_be) == 1 |-> mem_wdata == {LANES{mem_wdata[7:0]}}); // R4

  AST_MISALIGN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    chk_word_op && chk_ea[LSB_W-1:0] != '0 |=> align_err && !mem_req); // R10

  AST_BYTE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    chk_byte_op |=> !align_err); // R10

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> mem_be == '0 && !mem_req); // R10

  AST_LOAD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_req) && $past(mem_be) == '0); // R9

  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sext |-> ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}); // R6

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zext |-> ld_data[DATA_W-1:8] == '0); // R7

endmodule

bind lsu_byte_lane lsu_byte_lane_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_base  (req_base),
  .req_offset(req_offset),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .ld_valid  (ld_valid),
  .ld_data   (ld_data),
  .align_err (align_err),
  .ev_issue  (ev_issue),
  .ev_sext   (ev_sext),
  .ev_zext   (ev_zext)
);

// File: tb/lsu_byte_lane_bench.sv
module lsu_byte_lane_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_src = '0;
  logic        mem_req;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        align_err;

  always #2 clk = ~clk;

  lsu_byte_lane u_lsu_byte_lane (
    .clk, .rst_n, .req_valid, .req_op, .req_base, .req_offset, .req_src,
    .mem_req, .mem_addr, .mem_be, .mem_wdata, .mem_rdata,
    .ld_valid, .ld_data, .align_err
  );

  // memory model: 16 words, combinational read, write at clock edge
  logic [31:0] mem [16];
  logic [31:0] shadow [16];

  function automatic logic [31:0] init_word(input int i);
    return 32'hA0B1C2D3 ^ (32'(i) * 32'h01030507);
  endfunction

  assign mem_rdata = mem[mem_addr[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
    end else if (mem_req) begin
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) mem[mem_addr[3:0]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
    end
  end

  // scoreboard
  logic [65:0] mem_q [$];
  string       mem_tag_q [$];
  logic [31:0] ld_q [$];
  string       ld_tag_q [$];
  int          err_q [$];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          running = 1'b0;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [31:0] base,
                      input logic [15:0] off, input logic [31:0] src, input string tag);
    logic [31:0] ea;
    logic [3:0]  w;
    int          sh;
    logic [7:0]  b;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = base; req_offset = off; req_src = src;
    ea = base + {{16{off[15]}}, off};
    w  = ea[5:2];
    sh = 8 * (3 - int'(ea[1:0]));
    b  = 8'(shadow[w] >> sh);
    case (op)
      3'd0: if (ea[1:0] != 2'b00) err_q.push_back(1);
            else begin
              mem_q.push_back({ea[31:2], 4'h0, 32'h0}); mem_tag_q.push_back(tag);
              ld_q.push_back(shadow[w]); ld_tag_q.push_back(tag);
            end
      3'd1: if (ea[1:0] != 2'b00) err_q.push_back(1);
            else begin
              mem_q.push_back({ea[31:2], 4'hF, src}); mem_tag_q.push_back(tag);
              shadow[w] = src;
            end
      3'd2, 3'd3: begin
        mem_q.push_back({ea[31:2], 4'h0, 32'h0}); mem_tag_q.push_back(tag);
        ld_q.push_back(op == 3'd2 ? 32'($signed(b)) : {24'h0, b}); ld_tag_q.push_back(tag);
      end
      3'd4: begin
        mem_q.push_back({ea[31:2], 4'b1000 >> ea[1:0], {4{src[7:0]}}}); mem_tag_q.push_back(tag);
        shadow[w][sh +: 8] = src[7:0];
      end
      default: ;
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      if (mem_req) begin
        if (mem_q.size() == 0) check(0, "R2 unexpected access", {mem_addr, mem_be, mem_wdata}, '0);
        else begin
          logic [65:0] e;
          string t;
          e = mem_q.pop_front(); t = mem_tag_q.pop_front();
          check({mem_addr, mem_be, mem_wdata} == e, t, {mem_addr, mem_be, mem_wdata}, e);
        end
      end
      if (ld_valid) begin
        if (ld_q.size() == 0) check(0, "R9 unexpected load result", 66'(ld_data), '0);
        else begin
          logic [31:0] e;
          string t;
          e = ld_q.pop_front(); t = ld_tag_q.pop_front();
          check(ld_data == e, t, 66'(ld_data), 66'(e));
        end
      end
      if (align_err) begin
        if (err_q.size() == 0) check(0, "R10 unexpected align_err", 66'(1), 66'(0));
        else begin
          int d;
          d = err_q.pop_front();
          check(1, "R10", 66'(1), 66'(d));
        end
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    check(0, "watchdog expired", '0, '1);
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check({mem_req, mem_be, mem_wdata, mem_addr, ld_valid, ld_data, align_err} == '0, "R11 reset outputs",
          66'({mem_req, mem_be, ld_valid, align_err}), '0);
    running = 1'b1;

    // R3 word store, R8 word load back, R6 byte loads of positive bytes
    send(3'd1, 32'h0000_0100, 16'h0000, 32'h1234_5678, "R3 word store");
    send(3'd0, 32'h0000_0100, 16'h0000, 32'h0, "R8 word load");
    for (int k = 0; k < 4; k++) send(3'd2, 32'h0000_0100, 16'(k), 32'h0, "R6 signed byte load");

    // R1 negative displacement, R6 sign fill and R7 zero fill
    send(3'd1, 32'h0000_0104, 16'h0000, 32'h80FF_7F01, "R3 word store");
    for (int k = 0; k < 4; k++) send(3'd2, 32'h0000_0108, 16'(k - 4), 32'h0, "R6 R1 signed byte load");
    for (int k = 0; k < 4; k++) send(3'd3, 32'h0000_0108, 16'(k - 4), 32'h0, "R7 R1 unsigned byte load");

    // R4 lane mapping, R5 merge seen by an immediate word load
    send(3'd4, 32'h0000_0110, 16'h0001, 32'hAAAA_AA5C, "R4 byte store lane 1");
    send(3'd0, 32'h0000_0110, 16'h0000, 32'h0, "R5 merged word");
    send(3'd4, 32'h0000_0114, 16'hFFFF, 32'h0000_00E7, "R4 byte store lane 3");
    send(3'd4, 32'h0000_0110, 16'h0000, 32'h1111_1191, "R4 byte store lane 0");
    send(3'd4, 32'h0000_0112, 16'h0000, 32'h0000_0026, "R4 byte store lane 2");
    send(3'd0, 32'h0000_0110, 16'h0000, 32'h0, "R5 merged word");
    send(3'd3, 32'h0000_0113, 16'h0000, 32'h0, "R7 byte load odd address");

    // R10 misaligned word accesses, store suppressed
    for (int k = 1; k < 4; k++) send(3'd0, 32'h0000_0100, 16'(k), 32'h0, "R10 misaligned load");
    for (int k = 1; k < 4; k++) send(3'd1, 32'h0000_0100, 16'(k), 32'hDEAD_BEEF, "R10 misaligned store");
    send(3'd0, 32'h0000_0100, 16'h0000, 32'h0, "R10 word unchanged");

    // R2 unused opcodes and idle requests
    send(3'd5, 32'h0000_0100, 16'h0000, 32'hFFFF_FFFF, "R2");
    send(3'd7, 32'h0000_0104, 16'h0000, 32'hFFFF_FFFF, "R2");
    @(negedge clk);
    req_valid = 1'b0; req_op = 3'd1; req_base = 32'h0000_0100; req_src = 32'hFFFF_FFFF;
    send(3'd0, 32'h0000_0100, 16'h0000, 32'h0, "R2 word unchanged");

    // R1 displacement extremes
    send(3'd1, 32'h0000_8000, 16'h8000, 32'hC0FF_EE00, "R1 most negative offset");
    send(3'd0, 32'h0000_0004, 16'h7FFC, 32'h0, "R1 most positive offset");
    send(3'd0, 32'hFFFF_FFFC, 16'h0008, 32'h0, "R1 wrap-around");
    idle(6);

    check(mem_q.size() == 0 && ld_q.size() == 0 && err_q.size() == 0, "R9 R10 all expected events seen",
          66'(mem_q.size() + ld_q.size() + err_q.size()), '0);
    summary();
  end

endmodule